// File: doc/BRIEF.md
# Wavefront Matching Allocator

This block pairs N requesters with N resources in one combinational pass. A request matrix comes in, one bit per requester/resource pair. A grant matrix goes out, and it is always a matching: no requester and no resource receives more than one grant. Cells are grouped into diagonals, where cell (row r, column c) lies on diagonal (r + c) mod N. Work starts on a priority diagonal and moves through the diagonals in ascending order, wrapping at N. Every request on the current diagonal whose row and column are still free is granted. Each grant then claims its row and column, and requests later in the sweep cannot use them.

The wraparound of the sweep creates no combinational path back into itself. There is one loop-free copy of the cell array for each possible priority diagonal. In each copy the row and column tokens enter fresh at that copy's starting diagonal and never feed back into it. A one-hot register selects which copy drives the output.

Each cycle in which the update strobe is high and at least one grant is made, the priority diagonal moves up by one, modulo N. The block is typically used as a crossbar or virtual-channel allocator inside a router.

Top module: `wavefront_alloc`

## Requirements
- R1: After reset the priority diagonal is INIT_DIAG (default 0), i.e. with all requests set, the cells (r,c) with (r+c) mod N = INIT_DIAG are granted.
- R2: A grant bit gnt_o[r*N+c] is only set when req_i[r*N+c] is set.
- R3: At most one grant is set in any row r (bits r*N .. r*N+N-1).
- R4: At most one grant is set in any column c (bits c, N+c, ..., (N-1)*N+c).
- R5: Every request on the current priority diagonal is granted.
- R6: Diagonals are visited in the order p, p+1, ..., p+N-1 (mod N). A request on a later diagonal is granted exactly when no earlier diagonal granted in its row or its column.
- R7: The result is maximal: no request is left ungranted while its row and its column both carry no grant.
- R8: On a rising clock edge with upd_i high and at least one grant, the priority diagonal advances from p to (p+1) mod N, wrapping from N-1 to 0.
- R9: On an edge with upd_i low, or with no grant made, the priority diagonal stays unchanged.
- R10: The grant output depends combinationally on req_i; a change of req_i is visible on gnt_o within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the priority register |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N*N | Request matrix, bit r*N+c = requester r wants resource c |
| upd_i | input | 1 | Advance strobe for the priority diagonal |
| gnt_o | output | N*N | Grant matrix, same bit layout as req_i |

## Verification
The bench first rotates the priority through every diagonal and past the wrap from N-1 to 0 under a full request matrix. A register that rotated the wrong way, or failed to wrap, would grant the wrong diagonal. Strobes with an empty request matrix and cycles with the strobe low are checked to leave the priority in place; a design that advanced on the bare strobe would shift every later result by one diagonal. Dense, sparse and structured patterns check that the grants match the sweep order and stay maximal. Single-row and single-column requests are chosen to catch a design that drops tokens or lets a claimed row be granted twice. Requests that change inside one cycle expose any register left in the grant path.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

   // diagonal number of the cell at (row, col) in an n x n matrix
   function automatic int diag_of(input int row, input int col, input int n);
      return (row + col) % n;
   endfunction

   // index of the predecessor position on a ring of n
   function automatic int ring_prev(input int k, input int n);
      return (k + n - 1) % n;
   endfunction

endpackage

// File: rtl/wfa_cell.sv
module wfa_cell (
   input  logic req_i,
   input  logic row_free_i,
   input  logic col_free_i,
   output logic gnt_o,
   output logic row_free_o,
   output logic col_free_o
);
   assign gnt_o      = req_i & row_free_i & col_free_i;
   assign row_free_o = row_free_i & ~gnt_o;
   assign col_free_o = col_free_i & ~gnt_o;
endmodule

// File: rtl/wfa_plane.sv
module wfa_plane
   import wfa_pkg::*;
#(
   parameter int N = 4,
   parameter int P = 0
) (
   input  logic [N*N-1:0] req_i,
   output logic [N*N-1:0] gnt_o
);
   localparam int NN = N * N;

   if (P < 0 || P >= N) begin : g_bad_p
      $error("wfa_plane: P must lie in 0..N-1");
   end

   logic [NN-1:0] row_tok;
   logic [NN-1:0] col_tok;

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         localparam int D  = diag_of(r, c, N);
         localparam int CP = ring_prev(c, N);
         localparam int RP = ring_prev(r, N);
         logic rin, cin;
         if (D == P) begin : g_start
            // the sweep starts here: tokens enter fresh, loop is cut
            assign rin = 1'b1;
            assign cin = 1'b1;
         end else begin : g_chain
            assign rin = row_tok[r*N + CP];
            assign cin = col_tok[RP*N + c];
         end
         wfa_cell u_cell (
            .req_i      (req_i[r*N + c]),
            .row_free_i (rin),
            .col_free_i (cin),
            .gnt_o      (gnt_o[r*N + c]),
            .row_free_o (row_tok[r*N + c]),
            .col_free_o (col_tok[r*N + c])
         );
      end
   end
endmodule

// File: rtl/wfa_prio.sv
module wfa_prio #(
   parameter int N         = 4,
   parameter int INIT_DIAG = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [N-1:0] prio_o
);
   localparam logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1} << INIT_DIAG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prio_o <= RST_VAL;
      else if (adv_i) prio_o <= {prio_o[N-2:0], prio_o[N-1]};
   end

   // R8
   prio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(prio_o) == 1);
endmodule

// File: rtl/wavefront_alloc.sv
module wavefront_alloc
   import wfa_pkg::*;
#(
   parameter int N         = 4,
   parameter int INIT_DIAG = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N*N-1:0] req_i,
   input  logic           upd_i,
   output logic [N*N-1:0] gnt_o
);
   localparam int NN = N * N;

   if (N < 2) begin : g_bad_n
      $error("wavefront_alloc: N must be at least 2");
   end
   if (INIT_DIAG < 0 || INIT_DIAG >= N) begin : g_bad_init
      $error("wavefront_alloc: INIT_DIAG must lie in 0..N-1");
   end

   logic [N-1:0]  prio;
   logic [NN-1:0] plane_gnt [N];
   logic          adv;

   // one loop-free sweep per possible starting diagonal
   for (genvar p = 0; p < N; p++) begin : g_plane
      wfa_plane #(.N(N), .P(p)) u_plane (
         .req_i (req_i),
         .gnt_o (plane_gnt[p])
      );
   end

   always_comb begin
      gnt_o = '0;
      for (int p = 0; p < N; p++)
         if (prio[p]) gnt_o |= plane_gnt[p];
   end

   assign adv = upd_i & (|gnt_o);

   wfa_prio #(.N(N), .INIT_DIAG(INIT_DIAG)) u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (adv),
      .prio_o (prio)
   );

   // ---------------- checks ----------------
   logic [N-1:0] row_any, col_any;
   logic [N-1:0] col_vec [N];
   always_comb begin
      row_any = '0;
      col_any = '0;
      for (int c = 0; c < N; c++) col_vec[c] = '0;
      for (int r = 0; r < N; r++) begin
         row_any[r] = |gnt_o[r*N +: N];
         for (int c = 0; c < N; c++) begin
            col_vec[c][r] = gnt_o[r*N + c];
            col_any[c]    = col_any[c] | gnt_o[r*N + c];
         end
      end
   end

   // R2
   gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);

   for (genvar k = 0; k < N; k++) begin : g_line_chk
      // R3
      row_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(gnt_o[k*N +: N]) <= 1);
      // R4
      col_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(col_vec[k]) <= 1);
   end

   for (genvar r = 0; r < N; r++) begin : g_cell_chk
      for (genvar c = 0; c < N; c++) begin : g_c
         localparam int D = diag_of(r, c, N);
         // R5
         prio_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prio[D] && req_i[r*N + c]) |-> gnt_o[r*N + c]);
         // R7
         maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[r*N + c] && !gnt_o[r*N + c]) |-> (row_any[r] || col_any[c]));
      end
   end

   // R8
   prio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && (|gnt_o)) |=> prio == {$past(prio[N-2:0]), $past(prio[N-1])});
   // R9
   prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_i && (|gnt_o)) |=> $stable(prio));
endmodule

// File: tb/tb_wavefront_alloc.sv
`timescale 1ns/1ps
module tb_wavefront_alloc;
   localparam int N  = 4;
   localparam int NN = N * N;
   localparam time HALF = 10ns;

   typedef struct {
      logic [NN-1:0] req;
      logic [NN-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NN-1:0] req_i = '0;
   logic          upd_i = 1'b0;
   logic [NN-1:0] gnt_o;

   int    n_chk = 0;
   int    n_bad = 0;
   int    m_prio = 0;
   bit    drv_done = 1'b0;
   bit    finished = 1'b0;
   item_t sb_q[$];

   wavefront_alloc #(.N(N), .INIT_DIAG(0)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .upd_i(upd_i), .gnt_o(gnt_o)
   );

   always #HALF clk = ~clk;

   function automatic logic [NN-1:0] model(input logic [NN-1:0] r, input int p);
      logic [N-1:0]  rt, ct;
      logic [NN-1:0] g;
      rt = '0; ct = '0; g = '0;
      for (int k = 0; k < N; k++) begin
         int d;
         d = (p + k) % N;
         for (int i = 0; i < N; i++) begin
            int j;
            j = (d - i + N) % N;
            if (r[i*N+j] && !rt[i] && !ct[j]) begin
               g[i*N+j] = 1'b1; rt[i] = 1'b1; ct[j] = 1'b1;
            end
         end
      end
      return g;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [NN-1:0] act, input logic [NN-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and push the expected grants
   task automatic drive(input logic [NN-1:0] r, input logic u, input string tag);
      item_t it;
      @(negedge clk);
      req_i = r;
      upd_i = u;
      it.req = r;
      it.exp = model(r, m_prio);
      it.tag = tag;
      sb_q.push_back(it);
      if (u && (|it.exp)) m_prio = (m_prio + 1) % N;
   endtask

   // monitor: compare results and structural properties of every grant
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t it;
            logic [N-1:0] ra, ca;
            bit ok_row, ok_col, ok_max;
            it = sb_q.pop_front();
            chk(gnt_o === it.exp, it.tag, gnt_o, it.exp);
            chk((gnt_o & ~it.req) == '0, "R2", gnt_o, it.req);
            ra = '0; ca = '0; ok_row = 1'b1; ok_col = 1'b1; ok_max = 1'b1;
            for (int i = 0; i < N; i++) begin
               int rc, cc;
               rc = 0; cc = 0;
               for (int j = 0; j < N; j++) begin
                  rc += int'(gnt_o[i*N+j]);
                  cc += int'(gnt_o[j*N+i]);
               end
               if (rc > 1) ok_row = 1'b0;
               if (cc > 1) ok_col = 1'b0;
               ra[i] = (rc != 0);
               ca[i] = (cc != 0);
            end
            for (int i = 0; i < N; i++)
               for (int j = 0; j < N; j++)
                  if (it.req[i*N+j] && !gnt_o[i*N+j] && !ra[i] && !ca[j]) ok_max = 1'b0;
            chk(ok_row, "R3", gnt_o, it.exp);
            chk(ok_col, "R4", gnt_o, it.exp);
            chk(ok_max, "R7", gnt_o, it.exp);
         end
      end
   end

   // stimulus
   initial begin
      logic [NN-1:0] full, a, b;
      full = '1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset diagonal 0 -> (0,0),(1,3),(2,2),(3,1)
      drive(full, 1'b0, "R1");
      drive(full, 1'b0, "R9 hold without strobe");
      // R8: step through all diagonals and wrap back to 0
      for (int k = 0; k < N + 1; k++) drive(full, 1'b1, "R8 advance/wrap");
      // R9: strobe with no requests must not move the priority
      drive('0, 1'b1, "R9 empty strobe");
      drive(full, 1'b0, "R9 after empty strobe");
      // R5/R6 structured patterns
      drive(16'h000F, 1'b0, "R6 single row");
      drive(16'h1111, 1'b0, "R6 single column");
      drive(16'h8421, 1'b1, "R5 anti-diagonal");
      drive(16'h1248, 1'b1, "R5 diagonal");
      drive(16'h0020, 1'b1, "R5 single request");
      drive(16'hF00F, 1'b0, "R6 two rows");
      drive(16'h9999, 1'b1, "R6 two columns");
      // R6: random dense and sparse matrices with random strobes
      for (int k = 0; k < 300; k++) begin
         logic [NN-1:0] r;
         r = NN'($urandom);
         if (k % 3 == 1) r = r & NN'($urandom);
         if (k % 3 == 2) r = r | NN'($urandom);
         drive(r, 1'($urandom), "R6 random");
      end

      // R10: grants follow req_i inside one cycle, no register in the path
      @(negedge clk);
      #5;
      upd_i = 1'b0;
      a = 16'h00F0;
      b = 16'h0F00;
      req_i = a;
      #2 chk(gnt_o === model(a, m_prio), "R10 first value", gnt_o, model(a, m_prio));
      req_i = b;
      #2 chk(gnt_o === model(b, m_prio), "R10 second value", gnt_o, model(b, m_prio));

      drive(full, 1'b0, "R9 final priority");
      @(negedge clk);
      @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin
      wait (drv_done && sb_q.size() == 0);
      #5;
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(2 * HALF * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule